// File: doc/BRIEF.md
# Programmable Line Shift-Clock Pulse Generator

This block produces one shift-clock pulse per horizontal line for a panel interface. Each line begins with a line-start strobe, which sets the reference point. A position counter then advances on a divided dot-clock enable, so one step is one counting clock and not one raw dot clock. Two register fields set the pulse: a start offset that says how many counting clocks after the reference the pulse rises, and a high width. Both shift-clock outputs carry the same pulse.

Register writes are held in a pending copy. The copy becomes active only at a line start, so the timing never changes in the middle of a line. The panel-type bit and the display-mode field are also sampled at each line start. The programmed pulse is used only for a poly-silicon panel in dot-clock display mode. For the other panel type, the fields are ignored and a fixed line clock is produced instead. That line clock is low from the reference point and rises eight counting clocks later. Stopping the display drives every output low at once.

The sequencing is one state machine with these states:
- ST_STOP: outputs low, waiting for a line start while running.
- ST_PRE: before the rise.
- ST_PULSE: shift clocks high.
- ST_POST: pulse finished, or zero width.
- ST_FIX_LOW and ST_FIX_HIGH: the two halves of the fixed line clock.
- ST_IDLE: poly-silicon panel in a mode other than dot-clock.

Its transitions are:
- stop: any state goes to ST_STOP when the mode is 00.
- line load: at a line start, the machine moves to the state that fits position 0 under the new settings and mode.
- rise: ST_PRE to ST_PULSE.
- fall: ST_PULSE to ST_POST.
- fixed rise: ST_FIX_LOW to ST_FIX_HIGH.
- hold: every other case keeps the current state.

Top module: `lsc_shift_clk_gen`

## Requirements
- R1: An active-low synchronous reset clears both register fields, the pending copy and the position counter. While reset is applied, and afterwards until a line start with a non-zero mode, all three outputs are low.
- R2: A write (wr_en high) captures wr_data[2:0] as the start offset and wr_data[13:8] as the width. rd_data returns the pending fields in those same bit positions, and every other bit of rd_data reads zero.
- R3: Written values become active at the next line start. A write in the same cycle as a line start is applied only at the line start after it.
- R4: Position p is 0 in the cycle after a line-start edge. It increases by one after every other edge that samples cnt_en high. In programmed mode (panel bit 1, mode 2'b01), the shift clocks are high exactly when offset <= p < offset + width.
- R5: A width of 0 produces no pulse in that line.
- R6: A line start during a pulse ends it and restarts the timing from the new reference.
- R7: sclk_a and sclk_b are always equal. A shift clock and the line clock are never high together.
- R8: With panel bit 0 and a non-zero mode, the register fields are ignored. The shift clocks stay low and the line clock is low for p < 8 and high for p >= 8.
- R9: With panel bit 1 and mode 2'b10 or 2'b11, all outputs are low.
- R10: Mode 2'b00 forces all outputs low from the next edge. They stay low until a line start that sees a non-zero mode.
- R11: The position advances only on cnt_en and saturates at 255. It does not wrap.
- R12: A change of the panel bit or of a non-zero mode takes effect only at the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Divided dot-clock enable, one counting step |
| line_start | input | 1 | Line-start strobe, defines the reference point |
| ltps_panel | input | 1 | Panel-type bit, 1 enables programmed timing |
| disp_mode | input | 2 | Display mode: 00 stopped, 01 dot-clock driven |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write word |
| rd_data | output | 16 | Pending register word |
| sclk_a | output | 1 | Shift clock, first copy |
| sclk_b | output | 1 | Shift clock, second copy |
| lclk | output | 1 | Fixed-timing line clock |

## Verification
The assertions check these on every cycle:
- The pulse only appears inside the window of the active fields and never with a zero width.
- The line clock is never high before position 8.
- The shift and line clocks never overlap.
- The active fields never change without a line start.
- A stopped mode always reaches the stop state.

Only the bench scenarios can show these:
- Exact rise and fall positions under different enable rates.
- Saturation on long lines.
- Deferral of both writes and mode changes to the following line.
- Truncation at an early line start.
- The read-back encoding.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int LSC_RISE_W  = 3;
    localparam int LSC_WIDTH_W = 6;
    localparam int LSC_DATA_W  = 16;
    localparam int LSC_WIDTH_LSB = 8;
    localparam int LSC_CNT_W   = 8;
    localparam int LSC_FIX_RISE = 8;

    localparam logic [1:0] MODE_STOP = 2'b00;
    localparam logic [1:0] MODE_DOT  = 2'b01;

    typedef enum logic [2:0] {
        ST_STOP     = 3'd0,
        ST_PRE      = 3'd1,
        ST_PULSE    = 3'd2,
        ST_POST     = 3'd3,
        ST_FIX_LOW  = 3'd4,
        ST_FIX_HIGH = 3'd5,
        ST_IDLE     = 3'd6
    } lsc_state_e;

endpackage

// File: rtl/lsc_cfg_regs.sv
module lsc_cfg_regs
    import lsc_pkg::*;
#(
    parameter int RISE_W    = LSC_RISE_W,
    parameter int WIDTH_W   = LSC_WIDTH_W,
    parameter int DATA_W    = LSC_DATA_W,
    parameter int WIDTH_LSB = LSC_WIDTH_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               line_start,
    output logic [DATA_W-1:0]  rd_data,
    output logic [RISE_W-1:0]  act_rise,
    output logic [WIDTH_W-1:0] act_width,
    output logic [RISE_W-1:0]  eff_rise,
    output logic [WIDTH_W-1:0] eff_width
);

    logic [RISE_W-1:0]  pend_rise;
    logic [WIDTH_W-1:0] pend_width;

    // Pending copy: written by the port, transferred at line start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_rise  <= '0;
            pend_width <= '0;
            act_rise   <= '0;
            act_width  <= '0;
        end else begin
            if (line_start) begin
                act_rise  <= pend_rise;
                act_width <= pend_width;
            end
            if (wr_en) begin
                pend_rise  <= wr_data[RISE_W-1:0];
                pend_width <= wr_data[WIDTH_LSB +: WIDTH_W];
            end
        end
    end

    // Settings seen by the sequencer for the position being entered.
    always_comb begin
        eff_rise  = line_start ? pend_rise  : act_rise;
        eff_width = line_start ? pend_width : act_width;
    end

    always_comb begin
        rd_data = '0;
        rd_data[RISE_W-1:0]          = pend_rise;
        rd_data[WIDTH_LSB +: WIDTH_W] = pend_width;
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> ($stable(act_rise) && $stable(act_width))); // R3

endmodule

// File: rtl/lsc_pos_counter.sv
module lsc_pos_counter
    import lsc_pkg::*;
#(
    parameter int CNT_W = LSC_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cnt_en,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_comb begin
        if (clr)
            cnt_nxt = '0;
        else if (cnt_en && (cnt != CNT_MAX))
            cnt_nxt = cnt + 1'b1;
        else
            cnt_nxt = cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R4

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !cnt_en) |=> $stable(cnt)); // R11

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (cnt == CNT_MAX)) |=> (cnt == CNT_MAX)); // R11

endmodule

// File: rtl/lsc_line_fsm.sv
module lsc_line_fsm
    import lsc_pkg::*;
#(
    parameter int RISE_W   = LSC_RISE_W,
    parameter int WIDTH_W  = LSC_WIDTH_W,
    parameter int CNT_W    = LSC_CNT_W,
    parameter int FIX_RISE = LSC_FIX_RISE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic               ltps_panel,
    input  logic [1:0]         disp_mode,
    input  logic [CNT_W-1:0]   pos_nxt,
    input  logic [RISE_W-1:0]  eff_rise,
    input  logic [WIDTH_W-1:0] eff_width,
    output logic               sclk,
    output logic               lclk
);

    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] FIX_POS = SUM_W'(FIX_RISE);

    lsc_state_e state, state_nxt;

    logic [SUM_W-1:0] pos_ext, rise_ext, end_ext;
    lsc_state_e prog_state, fix_state;

    always_comb begin
        pos_ext  = SUM_W'(pos_nxt);
        rise_ext = SUM_W'(eff_rise);
        end_ext  = rise_ext + SUM_W'(eff_width);
    end

    // Classification of the next position under programmed timing.
    always_comb begin
        if (eff_width == '0)
            prog_state = ST_POST;
        else if (pos_ext < rise_ext)
            prog_state = ST_PRE;
        else if (pos_ext < end_ext)
            prog_state = ST_PULSE;
        else
            prog_state = ST_POST;
    end

    // Classification under the fixed line-clock waveform.
    always_comb begin
        fix_state = (pos_ext < FIX_POS) ? ST_FIX_LOW : ST_FIX_HIGH;
    end

    always_comb begin
        state_nxt = state;
        if (disp_mode == MODE_STOP) begin
            state_nxt = ST_STOP;
        end else if (line_start) begin
            if (!ltps_panel)
                state_nxt = fix_state;
            else if (disp_mode == MODE_DOT)
                state_nxt = prog_state;
            else
                state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_STOP, ST_IDLE:            state_nxt = state;
                ST_PRE, ST_PULSE, ST_POST:   state_nxt = prog_state;
                ST_FIX_LOW, ST_FIX_HIGH:     state_nxt = fix_state;
                default:                     state_nxt = ST_STOP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_STOP;
        else
            state <= state_nxt;
    end

    always_comb begin
        sclk = 1'b0;
        lclk = 1'b0;
        unique case (state)
            ST_PULSE:    sclk = 1'b1;
            ST_FIX_HIGH: lclk = 1'b1;
            default: begin
                sclk = 1'b0;
                lclk = 1'b0;
            end
        endcase
    end

    AST_STOP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_mode == MODE_STOP) |=> (state == ST_STOP)); // R10

    AST_STOP_UNTIL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_STOP) && !line_start) |=> (state == ST_STOP)); // R10

endmodule

// File: rtl/lsc_shift_clk_gen.sv
module lsc_shift_clk_gen
    import lsc_pkg::*;
#(
    parameter int RISE_W    = LSC_RISE_W,
    parameter int WIDTH_W   = LSC_WIDTH_W,
    parameter int DATA_W    = LSC_DATA_W,
    parameter int WIDTH_LSB = LSC_WIDTH_LSB,
    parameter int CNT_W     = LSC_CNT_W,
    parameter int FIX_RISE  = LSC_FIX_RISE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              line_start,
    input  logic              ltps_panel,
    input  logic [1:0]        disp_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk_a,
    output logic              sclk_b,
    output logic              lclk
);

    localparam int SUM_W = CNT_W + 1;

    logic [RISE_W-1:0]  act_rise, eff_rise;
    logic [WIDTH_W-1:0] act_width, eff_width;
    logic [CNT_W-1:0]   pos, pos_nxt;
    logic               sclk;

    lsc_cfg_regs #(
        .RISE_W(RISE_W), .WIDTH_W(WIDTH_W),
        .DATA_W(DATA_W), .WIDTH_LSB(WIDTH_LSB)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .line_start(line_start), .rd_data(rd_data),
        .act_rise(act_rise), .act_width(act_width),
        .eff_rise(eff_rise), .eff_width(eff_width)
    );

    lsc_pos_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .clr(line_start), .cnt_en(cnt_en),
        .cnt(pos), .cnt_nxt(pos_nxt)
    );

    lsc_line_fsm #(
        .RISE_W(RISE_W), .WIDTH_W(WIDTH_W),
        .CNT_W(CNT_W), .FIX_RISE(FIX_RISE)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .ltps_panel(ltps_panel), .disp_mode(disp_mode),
        .pos_nxt(pos_nxt), .eff_rise(eff_rise), .eff_width(eff_width),
        .sclk(sclk), .lclk(lclk)
    );

    assign sclk_a = sclk;
    assign sclk_b = sclk;

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (!sclk_a && !sclk_b && !lclk && (pos == '0))); // R1

    AST_PULSE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_a |-> ((SUM_W'(pos) >= SUM_W'(act_rise)) &&
                    (SUM_W'(pos) < SUM_W'(act_rise) + SUM_W'(act_width)))); // R4

    AST_NO_ZERO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_a |-> (act_width != '0)); // R5

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_a && lclk)); // R7

    AST_FIX_EARLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        lclk |-> (SUM_W'(pos) >= SUM_W'(FIX_RISE))); // R8

    AST_STOP_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_mode == MODE_STOP) |=> (!sclk_a && !lclk)); // R10

endmodule

// File: tb/test_lsc_shift_clk_gen.sv
module test_lsc_shift_clk_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        line_start = 1'b0;
    logic        ltps_panel = 1'b1;
    logic [1:0]  disp_mode = 2'b01;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        sclk_a, sclk_b, lclk;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Behavioural reference state.
    int pos = 0, arise = 0, awidth = 0, prise = 0, pwidth = 0;
    int kind = 0; // 0 stopped, 1 programmed, 2 fixed, 3 idle

    always #4 clk = ~clk;

    lsc_shift_clk_gen i_lsc_shift_clk_gen (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .line_start(line_start),
        .ltps_panel(ltps_panel), .disp_mode(disp_mode),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .sclk_a(sclk_a), .sclk_b(sclk_b), .lclk(lclk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            pos = 0; arise = 0; awidth = 0; prise = 0; pwidth = 0; kind = 0;
        end else begin
            if (line_start) begin
                arise = prise; awidth = pwidth; pos = 0;
            end else if (cnt_en && pos < 255) begin
                pos++;
            end
            if (disp_mode == 2'b00) kind = 0;
            else if (line_start) kind = !ltps_panel ? 2 : (disp_mode == 2'b01 ? 1 : 3);
            if (wr_en) begin
                prise  = int'(wr_data[2:0]);
                pwidth = int'(wr_data[13:8]);
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            bit es, el;
            es = (kind == 1) && (pos >= arise) && (pos < arise + awidth);
            el = (kind == 2) && (pos >= 8);
            chk(sclk_a == es, cur_req, int'(sclk_a), int'(es));
            chk(sclk_b == es, "R7", int'(sclk_b), int'(es));
            chk(lclk == el, cur_req, int'(lclk), int'(el));
        end
    end

    task automatic run_line(input int ncyc, input int per);
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            line_start = (i == 0);
            cnt_en = (per > 0) && ((i % per) == 0);
        end
        @(negedge clk);
        line_start = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic run_cont(input int ncyc, input int per);
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            line_start = 1'b0;
            cnt_en = (per > 0) && ((i % per) == 0);
        end
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic write_reg(input logic [15:0] d, input int exp_rd);
        @(negedge clk);
        line_start = 1'b0; cnt_en = 1'b0;
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_data == 16'(exp_rd), "R2", int'(rd_data), exp_rd);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(rd_data == 16'h0000, "R1", int'(rd_data), 0);
        rst_n = 1'b1;
        cur_req = "R1";
        run_cont(6, 1);

        // R2 field capture and read-back.
        write_reg(16'h3F07, 16'h3F07);
        write_reg(16'hFFFF, 16'h3F07);
        write_reg(16'hC0F8, 16'h0000);

        // R4 programmed pulse at several enable rates.
        cur_req = "R4";
        write_reg(16'h0A02, 16'h0A02);
        run_line(40, 2);
        run_line(40, 3);
        write_reg(16'h0300, 16'h0300);
        run_line(20, 1);

        // R11 long line with the widest settings.
        cur_req = "R11";
        write_reg(16'h3F07, 16'h3F07);
        run_line(300, 1);

        cur_req = "R5";
        write_reg(16'h0004, 16'h0004);
        run_line(30, 1);
        run_line(30, 1);

        cur_req = "R6";
        write_reg(16'h3201, 16'h3201);
        run_line(20, 1);
        run_line(20, 1);

        // R3 mid-line write and write coinciding with line start.
        cur_req = "R3";
        write_reg(16'h0502, 16'h0502);
        run_line(10, 1);
        write_reg(16'h0204, 16'h0204);
        run_cont(20, 1);
        @(negedge clk);
        line_start = 1'b1; wr_en = 1'b1; wr_data = 16'h0803;
        @(negedge clk);
        line_start = 1'b0; wr_en = 1'b0;
        run_cont(20, 1);
        run_line(20, 1);

        // R8 fixed line clock, fields ignored.
        cur_req = "R8";
        ltps_panel = 1'b0;
        write_reg(16'h0101, 16'h0101);
        run_line(20, 1);
        run_line(30, 2);
        disp_mode = 2'b10;
        run_line(20, 1);
        cur_req = "R11";
        disp_mode = 2'b01;
        run_line(300, 1);

        cur_req = "R9";
        ltps_panel = 1'b1;
        write_reg(16'h0A00, 16'h0A00);
        disp_mode = 2'b10;
        run_line(20, 1);
        disp_mode = 2'b11;
        run_line(20, 1);

        cur_req = "R10";
        disp_mode = 2'b01;
        run_line(6, 1);
        disp_mode = 2'b00;
        run_cont(8, 1);
        disp_mode = 2'b01;
        run_cont(10, 1);
        run_line(20, 1);

        cur_req = "R12";
        write_reg(16'h1400, 16'h1400);
        run_line(5, 1);
        ltps_panel = 1'b0;
        run_cont(20, 1);
        run_line(20, 1);
        ltps_panel = 1'b1;
        disp_mode = 2'b11;
        run_cont(10, 1);
        disp_mode = 2'b01;
        run_line(30, 1);

        cur_req = "R1";
        run_line(5, 1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(rd_data == 16'h0000, "R1", int'(rd_data), 0);
        rst_n = 1'b1;
        run_cont(10, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule